// File: doc/BRIEF.md
# Attribute-Configurable Register Bank

This block is a small bank of control and status registers in which every single bit is given its own access behaviour when the design is elaborated. A parameter vector carries a 4-bit attribute code for each bit. A second mask marks the bits that keep their value through a software reset. A third vector gives the reset value of each bit. The result is a mix of plain configuration bits, sticky status flags, command bits that clear themselves and monitored conditions, all in one register file.

Software reaches the bank over a simple synchronous bus with these signals:

- a word address;
- a write strobe with write data;
- a read strobe, with the read data returned one cycle later.

Hardware reaches the bank in two ways:

- It drives three per-bit vectors: one-cycle set events, level conditions, and completion pulses for self-clearing and self-setting bits.
- It sees the live state of every bit on a flat output vector.

Top module: `attr_regbank`

## Requirements
- R1: Bit i sits in word i/DW at column i%DW. Its attribute code is ATTR[4i+3:4i]: 0 read/write, 1 read-only, 2 write-only, 3 write-1-to-clear, 4 write-any-to-clear, 5 clear-on-read, 6 self-clearing, 7 self-setting, 8 latch-high, 9 latch-low. A read strobe loads rdata on the next edge with the addressed word. An address at or above NREG returns zero. Without a strobe, rdata holds its value.
- R2: A read/write bit takes the write data bit when its word is written, and reads back its current value.
- R3: A read-only bit holds hw_cond sampled at the previous edge, and writes have no effect on it.
- R4: A write-only bit stores writes like a read/write bit and shows them on `fields`, but always reads as 0.
- R5: A write-1-to-clear bit is set by hw_evt. Writing 1 clears it and writing 0 leaves it unchanged.
- R6: A write-any-to-clear bit is set by hw_evt, and any write to its word clears it whatever the data.
- R7: A clear-on-read bit is set by hw_evt and ignores writes. A read returns its value and clears it on the same edge, so the following read returns 0.
- R8: When hw_evt on a bit arrives in the same cycle as a write or read that would clear it, the bit ends up set.
- R9: A self-clearing bit is set by writing 1 and returns to 0 on a hw_done pulse. Writing 0 does nothing, and a write of 1 wins over a simultaneous hw_done.
- R10: A self-setting bit is cleared by writing 0 and returns to 1 on a hw_done pulse. Writing 1 does nothing.
- R11: A latch-high bit becomes 1 whenever hw_cond is 1 and stays 1 until its word is read. After that read it follows hw_cond.
- R12: A latch-low bit becomes 0 whenever hw_cond is 0 and stays 0 until its word is read. After that read it follows hw_cond.
- R13: soft_rst returns every bit outside the KEEP mask to its RSTV value on the next edge. Bits inside the mask behave as if soft_rst were low.
- R14: An active-low rst_n sets every bit to RSTV and rdata to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| addr | input | AW | Word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| hw_evt | input | NREG*DW | Per-bit set events |
| hw_cond | input | NREG*DW | Per-bit level conditions |
| hw_done | input | NREG*DW | Per-bit completion pulses for self-clear and self-set bits |
| fields | output | NREG*DW | Current value of every bit |

## Verification
The bound assertions check the following on every cycle:

- set events always leave the bit set;
- latch-high bits are 1 after a high condition, and latch-low bits are 0 after a low condition;
- read-only bits track the sampled condition;
- write-only columns read as zero;
- software reset loads the reset value, and bits in the keep mask hold through it.

Some behaviours depend on several cycles and on read ordering:

- a latched bit is released only by a read;
- a clear-on-read bit returns its value before it clears;
- a self-clearing or self-setting bit completes only on the done pulse;
- a hard reset taken mid-run restores the reset values.

These appear only in the bench's directed and random scenarios. In those scenarios the behavioural model is compared with the outputs on every clock.

// File: rtl/attr_regbank.sv
module attr_regbank #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter logic [4*NREG*DW-1:0] ATTR = 128'h00000000_00000000_98530098_76543210,
  parameter logic [NREG*DW-1:0]   RSTV = 32'h00A58280,
  parameter logic [NREG*DW-1:0]   KEEP = 32'h00F01400
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 soft_rst,
  input  logic [AW-1:0]        addr,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wdata,
  input  logic                 rd_en,
  output logic [DW-1:0]        rdata,
  input  logic [NREG*DW-1:0]   hw_evt,
  input  logic [NREG*DW-1:0]   hw_cond,
  input  logic [NREG*DW-1:0]   hw_done,
  output logic [NREG*DW-1:0]   fields
);
  localparam int NB = NREG * DW;

  logic [NB-1:0] q, d, vis;
  logic [DW-1:0] rd_mux;

  for (genvar i = 0; i < NB; i++) begin : g_bit
    localparam int R = i / DW;
    localparam int C = i % DW;
    localparam logic [3:0] A = ATTR[4*i +: 4];
    logic wh, rh, w, nx;

    assign wh = wr_en && (addr == AW'(R));
    assign rh = rd_en && (addr == AW'(R));
    assign w  = wdata[C];

    always_comb begin
      case (A)
        4'd0, 4'd2: nx = wh ? w : q[i];
        4'd1:       nx = hw_cond[i];
        4'd3:       nx = hw_evt[i] | (q[i] & ~(wh & w));
        4'd4:       nx = hw_evt[i] | (q[i] & ~wh);
        4'd5:       nx = hw_evt[i] | (q[i] & ~rh);
        4'd6:       nx = (wh & w) | (q[i] & ~hw_done[i]);
        4'd7:       nx = ~(wh & ~w) & (q[i] | hw_done[i]);
        4'd8:       nx = hw_cond[i] | (q[i] & ~rh);
        4'd9:       nx = hw_cond[i] & (q[i] | rh);
        default:    nx = q[i];
      endcase
    end

    assign d[i]   = (soft_rst && !KEEP[i]) ? RSTV[i] : nx;
    assign vis[i] = (A == 4'd2) ? 1'b0 : q[i];
  end

  always_comb begin
    rd_mux = '0;
    for (int r = 0; r < NREG; r++)
      if (addr == AW'(r)) rd_mux = vis[r*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= RSTV;
      rdata <= '0;
    end else begin
      q <= d;
      if (rd_en) rdata <= rd_mux;
    end
  end

  assign fields = q;
endmodule

// File: rtl/attr_regbank_chk.sv
module attr_regbank_chk #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  parameter int AW   = 3,
  parameter logic [4*NREG*DW-1:0] ATTR = '0,
  parameter logic [NREG*DW-1:0]   RSTV = '0,
  parameter logic [NREG*DW-1:0]   KEEP = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 soft_rst,
  input logic [AW-1:0]        addr,
  input logic                 wr_en,
  input logic [DW-1:0]        wdata,
  input logic                 rd_en,
  input logic [DW-1:0]        rdata,
  input logic [NREG*DW-1:0]   hw_evt,
  input logic [NREG*DW-1:0]   hw_cond,
  input logic [NREG*DW-1:0]   fields
);
  localparam int NB = NREG * DW;

  logic seen;
  logic unused_sink;
  assign unused_sink = ^{wdata, rdata, hw_evt, hw_cond, fields, addr, rd_en};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  for (genvar i = 0; i < NB; i++) begin : g_chk
    localparam int R = i / DW;
    localparam int C = i % DW;
    localparam logic [3:0] A = ATTR[4*i +: 4];

    if (!KEEP[i]) begin : g_sr
      a_r13_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(soft_rst) |-> fields[i] == RSTV[i]);
    end else if (A == 4'd0) begin : g_keep
      a_r13_keep_through_soft: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(soft_rst) && !$past(wr_en && addr == AW'(R)) |-> fields[i] == $past(fields[i]));
    end

    if (A == 4'd1) begin : g_ro
      a_r3_ro_tracks_cond: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(soft_rst) |-> fields[i] == $past(hw_cond[i]));
    end
    if (A == 4'd2) begin : g_wo
      a_r4_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(rd_en) && $past(addr) == AW'(R) |-> rdata[C] == 1'b0);
    end
    if (A == 4'd3 || A == 4'd4 || A == 4'd5) begin : g_set
      a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(hw_evt[i]) && !$past(soft_rst) |-> fields[i]);
    end
    if (A == 4'd6) begin : g_sc
      a_r9_sc_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(wr_en && addr == AW'(R) && wdata[C]) && !$past(soft_rst) |-> fields[i]);
    end
    if (A == 4'd8) begin : g_lh
      a_r11_lh_latches: assert property (@(posedge clk) disable iff (!rst_n)
        seen && $past(hw_cond[i]) && !$past(soft_rst) |-> fields[i]);
    end
    if (A == 4'd9) begin : g_ll
      a_r12_ll_latches: assert property (@(posedge clk) disable iff (!rst_n)
        seen && !$past(hw_cond[i]) && !$past(soft_rst) |-> !fields[i]);
    end
  end
endmodule

bind attr_regbank attr_regbank_chk #(
  .NREG(NREG), .DW(DW), .AW(AW), .ATTR(ATTR), .RSTV(RSTV), .KEEP(KEEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
  .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .hw_evt(hw_evt),
  .hw_cond(hw_cond), .fields(fields)
);

// File: tb/attr_regbank_test.sv
module attr_regbank_test;
  localparam int PERIOD = 10;
  localparam int NREG = 4, DW = 8, AW = 3, NB = NREG * DW;
  localparam logic [4*NB-1:0] ATTR = 128'h00000000_00000000_98530098_76543210;
  localparam logic [NB-1:0]   RSTV = 32'h00A58280;
  localparam logic [NB-1:0]   KEEP = 32'h00F01400;

  logic clk = 0, rst_n = 0, soft_rst = 0, wr_en = 0, rd_en = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NB-1:0] hw_evt = '0, hw_cond = '0, hw_done = '0, fields;

  logic [NB-1:0] mq;
  logic [DW-1:0] mrd;
  int ncmp = 0, nbad = 0;
  string tag = "R14";

  always #(PERIOD/2) clk = ~clk;

  attr_regbank #(.NREG(NREG), .DW(DW), .AW(AW), .ATTR(ATTR), .RSTV(RSTV), .KEEP(KEEP)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rd_en(rd_en), .rdata(rdata), .hw_evt(hw_evt),
    .hw_cond(hw_cond), .hw_done(hw_done), .fields(fields));

  function automatic int code(int i);
    return int'(ATTR[4*i +: 4]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq  = RSTV;
      mrd = '0;
    end else begin
      logic [NB-1:0] nq;
      nq = mq;
      for (int i = 0; i < NB; i++) begin
        bit wr_here, rd_here, b;
        wr_here = wr_en && int'(addr) == i / DW;
        rd_here = rd_en && int'(addr) == i / DW;
        b = wdata[i % DW];
        case (code(i))
          0, 2: if (wr_here) nq[i] = b;
          1: nq[i] = hw_cond[i];
          3: if (hw_evt[i]) nq[i] = 1; else if (wr_here && b) nq[i] = 0;
          4: if (hw_evt[i]) nq[i] = 1; else if (wr_here) nq[i] = 0;
          5: if (hw_evt[i]) nq[i] = 1; else if (rd_here) nq[i] = 0;
          6: if (wr_here && b) nq[i] = 1; else if (hw_done[i]) nq[i] = 0;
          7: if (wr_here && !b) nq[i] = 0; else if (hw_done[i]) nq[i] = 1;
          8: if (hw_cond[i]) nq[i] = 1; else if (rd_here) nq[i] = 0;
          9: if (!hw_cond[i]) nq[i] = 0; else if (rd_here) nq[i] = 1;
          default: ;
        endcase
        if (soft_rst && !KEEP[i]) nq[i] = RSTV[i];
      end
      if (rd_en) begin
        mrd = '0;
        if (int'(addr) < NREG)
          for (int c = 0; c < DW; c++)
            mrd[c] = (code(int'(addr) * DW + c) == 2) ? 1'b0 : mq[int'(addr) * DW + c];
      end
      mq = nq;
    end
  end

  task automatic tick();
    @(negedge clk);
    ncmp++;
    if (fields !== mq) begin
      nbad++;
      $display("FAIL %s fields actual %h expected %h", tag, fields, mq);
    end
    ncmp++;
    if (rdata !== mrd) begin
      nbad++;
      $display("FAIL %s rdata actual %h expected %h", tag, rdata, mrd);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] v);
    addr = AW'(a); wdata = v; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic rd(input int a);
    addr = AW'(a); rd_en = 1; tick(); rd_en = 0; tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    nbad++;
    $display("FAIL R1 watchdog actual hung expected done");
    summary();
  end

  initial begin
    tick(); tick(); rst_n = 1;
    tag = "R14"; for (int a = 0; a < NREG; a++) rd(a);
    tag = "R1";  rd(5); rd(7);
    tag = "R2";  wr(2, 8'h3C); rd(2); wr(3, 8'h5A); rd(3);
    tag = "R3";  hw_cond[1] = 1; tick(); wr(0, 8'h00); rd(0); hw_cond[1] = 0; tick(); rd(0);
    tag = "R4";  wr(0, 8'h04); rd(0); wr(0, 8'h00); rd(0);
    tag = "R5";  hw_evt[3] = 1; tick(); hw_evt[3] = 0;
                 wr(0, 8'h00); rd(0); wr(0, 8'h08); rd(0);
    tag = "R6";  hw_evt[4] = 1; tick(); hw_evt[4] = 0; wr(0, 8'h00); rd(0);
    tag = "R7";  hw_evt[5] = 1; tick(); hw_evt[5] = 0; wr(0, 8'h00); rd(0); rd(0);
    tag = "R8";  hw_evt[3] = 1; hw_evt[4] = 1; wr(0, 8'hFF); hw_evt = '0;
                 hw_evt[5] = 1; rd(0); hw_evt = '0; rd(0);
    tag = "R9";  wr(0, 8'h40); tick(); tick(); hw_done[6] = 1; tick(); hw_done[6] = 0;
                 wr(0, 8'h40); rd(0); hw_done[6] = 1; wr(0, 8'h40); hw_done[6] = 0; rd(0);
    tag = "R10"; wr(0, 8'h00); tick(); wr(0, 8'h80); hw_done[7] = 1; tick(); hw_done[7] = 0; rd(0);
    tag = "R11"; hw_cond[8] = 1; tick(); hw_cond[8] = 0; tick(); tick(); rd(1);
                 hw_cond[8] = 1; rd(1); hw_cond[8] = 0; rd(1); rd(1);
    tag = "R12"; hw_cond[9] = 1; hw_cond[15] = 1; tick(); tick(); rd(1);
                 hw_cond[9] = 0; tick(); hw_cond[9] = 1; tick(); tick(); rd(1);
    tag = "R13"; wr(1, 8'hFF); wr(2, 8'hFF); hw_evt[12] = 1; tick(); hw_evt = '0;
                 soft_rst = 1; tick(); soft_rst = 0; rd(0); rd(1); rd(2);
    tag = "R14"; wr(2, 8'h00); wr(3, 8'hFF); @(negedge clk); rst_n = 0; #1; rst_n = 1;
                 tick(); rd(2); rd(3);
    tag = "R1";
    for (int k = 0; k < 500; k++) begin
      addr     = AW'($urandom_range(0, 7));
      wdata    = DW'($urandom);
      wr_en    = ($urandom_range(0, 2) == 0);
      rd_en    = ($urandom_range(0, 2) == 0);
      hw_evt   = $urandom & $urandom;
      hw_cond  = $urandom;
      hw_done  = $urandom & $urandom;
      soft_rst = ($urandom_range(0, 30) == 0);
      tick();
    end
    wr_en = 0; rd_en = 0; soft_rst = 0; hw_evt = '0; hw_done = '0;
    tick();
    summary();
  end
endmodule